// File: doc/BRIEF.md
# Interleaved Video/CPU DRAM Slot Sequencer

This block lets a video address generator and a CPU share a single dynamic RAM with no arbitration at all. Every CPU cycle is eight ticks of the master clock, and it is cut into two fixed four-tick access slots. The first slot belongs to video and lines up with CPU phase 1. The second slot belongs to the CPU and lines up with CPU phase 2. Each slot runs its own complete row-strobe and column-strobe sequence, so the RAM sees two accesses per CPU cycle. Neither side ever waits and neither side ever sees a gap.

In each slot the sequencer picks the address source. It drives the row half and then the column half onto the shared address pins. It asserts write enable only for CPU writes, and it latches read data for whichever side owns the slot. For display modes with low bandwidth, the video side can ask for half-rate fetching. Every video slot still runs its strobes, but read data is taken only in every other CPU cycle, so the video side may present one byte address for two slots.

Top module: `dramSlotSeq`

## Requirements
- R1: While `rst` is high, `ramRasN`, `ramCasN` and `ramWeN` are 1, and `cpuPhi2` and `vidStrobe` are 0. After reset, `vidData` and `cpuRdata` read 0. The first cycle after `rst` falls is slot tick 0 of the video slot.
- R2: Number the eight ticks of a CPU cycle 0 to 7, and take the slot tick as the tick modulo 4. `ramRasN` is 0 on slot ticks 0, 1 and 2 and 1 on slot tick 3. `ramCasN` is 0 on slot ticks 1 and 2 only. This holds in both slots.
- R3: On slot tick 0, `ramAddr` carries the row half, which is the low `ADDR_W/2` bits of the selected address. On slot ticks 1 to 3 it carries the column half, which is the high `ADDR_W/2` bits.
- R4: Ticks 0 to 3 take their address from `vidAddr`. Ticks 4 to 7 take their address from `cpuAddr`.
- R5: `ramWeN` is 0 only on ticks 4, 5 and 6, and only while `cpuWrite` is 1. On every video tick and on tick 7 it is 1. `ramWdata` follows `cpuWdata`.
- R6: In full-rate mode (`vidHalfRate` = 0), `vidStrobe` is 1 on tick 2. `ramDin` is captured into `vidData` at the end of tick 2 and is visible from tick 3. Between captures, `vidData` holds its value.
- R7: With `vidHalfRate` = 1, video capture happens only in even CPU cycles, counting the first cycle after reset as 0. In odd cycles the video-slot strobes still run, but `vidStrobe` stays 0 and `vidData` holds.
- R8: When `cpuWrite` is 0, `ramDin` is captured into `cpuRdata` at the end of tick 6 and is visible from tick 7. It holds until the next CPU read capture, and a CPU write cycle leaves it unchanged.
- R9: `cpuPhi2` is 0 on ticks 0 to 3 and 1 on ticks 4 to 7, so it repeats every 8 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master tick clock |
| rst | input | 1 | Synchronous reset, active high |
| vidHalfRate | input | 1 | 1 selects half-rate video fetching |
| vidAddr | input | ADDR_W | Video byte address |
| cpuAddr | input | ADDR_W | CPU byte address |
| cpuWrite | input | 1 | 1 marks the current CPU cycle as a write |
| cpuWdata | input | DATA_W | CPU write data |
| ramDin | input | DATA_W | Read data from the RAM |
| ramAddr | output | ADDR_W/2 | Multiplexed row/column address |
| ramRasN | output | 1 | Row strobe, active low |
| ramCasN | output | 1 | Column strobe, active low |
| ramWeN | output | 1 | Write enable, active low |
| ramWdata | output | DATA_W | Write data to the RAM |
| cpuPhi2 | output | 1 | High during CPU phase 2 (the CPU slot) |
| vidStrobe | output | 1 | High on the tick whose end captures video data |
| vidData | output | DATA_W | Latched video byte |
| cpuRdata | output | DATA_W | Latched CPU read byte |

## Verification
The video fetch and a CPU write can land on the same byte within one CPU cycle. The bench sets up exactly that case by pointing both address inputs at the same location while the CPU slot writes a new value. The video byte captured in that cycle must be the old content, because the video slot comes first. The fetch in the next cycle must return the value just written. Half-rate mode is also run against changing video addresses, to confirm that skipped slots still strobe while leaving the latched byte untouched.

// File: rtl/dramSlotPkg.sv
package dramSlotPkg;
  localparam int TICK_W = 3;
  localparam int SLOT_W = 2;

  typedef struct packed {
    logic rowAct;
    logic colAct;
    logic addrCol;
    logic cpuSlot;
    logic weAct;
    logic vidCap;
    logic cpuCap;
  } slotStrobes_t;
endpackage

// File: rtl/slotCtrl.sv
module slotCtrl
  import dramSlotPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cpuWrite,
  input  logic         vidHalfRate,
  output slotStrobes_t strb
);
  logic [TICK_W-1:0] tick;
  logic              cycOdd;
  logic [SLOT_W-1:0] slotTick;

  assign slotTick = tick[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tick   <= '0;
      cycOdd <= 1'b0;
    end else begin
      tick <= tick + 1'b1;
      if (tick == '1) cycOdd <= !cycOdd;
    end
  end

  always_comb begin
    strb.rowAct  = !rst && (slotTick != 2'd3);
    strb.colAct  = !rst && ((slotTick == 2'd1) || (slotTick == 2'd2));
    strb.addrCol = !rst && (slotTick != 2'd0);
    strb.cpuSlot = !rst && tick[TICK_W-1];
    strb.weAct   = strb.cpuSlot && cpuWrite && (slotTick != 2'd3);
    strb.vidCap  = !rst && !tick[TICK_W-1] && (slotTick == 2'd2)
                   && (!vidHalfRate || !cycOdd);
    strb.cpuCap  = strb.cpuSlot && (slotTick == 2'd2) && !cpuWrite;
  end

  // R2
  ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.rowAct |=> strb.rowAct);

  // R2
  cas_after_row_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strb.rowAct) |-> !strb.colAct);

  // R9
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (slotTick == 2'd3) |=> (strb.cpuSlot != $past(strb.cpuSlot)));
endmodule

// File: rtl/slotData.sv
module slotData
  import dramSlotPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  slotStrobes_t        strb,
  input  logic [ADDR_W-1:0]   vidAddr,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W-1:0]   cpuWdata,
  input  logic [DATA_W-1:0]   ramDin,
  output logic [ADDR_W/2-1:0] ramAddr,
  output logic                ramRasN,
  output logic                ramCasN,
  output logic                ramWeN,
  output logic [DATA_W-1:0]   ramWdata,
  output logic                cpuPhi2,
  output logic                vidStrobe,
  output logic [DATA_W-1:0]   vidData,
  output logic [DATA_W-1:0]   cpuRdata
);
  localparam int ROW_W = ADDR_W / 2;

  logic [ADDR_W-1:0] srcAddr;

  assign srcAddr   = strb.cpuSlot ? cpuAddr : vidAddr;
  assign ramAddr   = strb.addrCol ? srcAddr[ADDR_W-1:ROW_W] : srcAddr[ROW_W-1:0];
  assign ramRasN   = !strb.rowAct;
  assign ramCasN   = !strb.colAct;
  assign ramWeN    = !strb.weAct;
  assign ramWdata  = cpuWdata;
  assign cpuPhi2   = strb.cpuSlot;
  assign vidStrobe = strb.vidCap;

  always_ff @(posedge clk) begin
    if (rst) begin
      vidData  <= '0;
      cpuRdata <= '0;
    end else begin
      if (strb.vidCap) vidData  <= ramDin;
      if (strb.cpuCap) cpuRdata <= ramDin;
    end
  end

  // R6
  vid_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strb.vidCap |=> (vidData == $past(ramDin)));

  // R7
  vid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.vidCap |=> $stable(vidData));

  // R8
  cpu_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strb.cpuCap |=> (cpuRdata == $past(ramDin)));

  // R8
  cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.cpuCap |=> $stable(cpuRdata));

  // R5
  we_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !ramWeN |-> (cpuPhi2 && !ramRasN));
endmodule

// File: rtl/dramSlotSeq.sv
module dramSlotSeq
  import dramSlotPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vidHalfRate,
  input  logic [ADDR_W-1:0]   vidAddr,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                cpuWrite,
  input  logic [DATA_W-1:0]   cpuWdata,
  input  logic [DATA_W-1:0]   ramDin,
  output logic [ADDR_W/2-1:0] ramAddr,
  output logic                ramRasN,
  output logic                ramCasN,
  output logic                ramWeN,
  output logic [DATA_W-1:0]   ramWdata,
  output logic                cpuPhi2,
  output logic                vidStrobe,
  output logic [DATA_W-1:0]   vidData,
  output logic [DATA_W-1:0]   cpuRdata
);
  slotStrobes_t strb;

  slotCtrl u_ctrl (
    .clk(clk), .rst(rst), .cpuWrite(cpuWrite),
    .vidHalfRate(vidHalfRate), .strb(strb)
  );

  slotData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strb(strb),
    .vidAddr(vidAddr), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .ramDin(ramDin),
    .ramAddr(ramAddr), .ramRasN(ramRasN), .ramCasN(ramCasN), .ramWeN(ramWeN),
    .ramWdata(ramWdata), .cpuPhi2(cpuPhi2), .vidStrobe(vidStrobe),
    .vidData(vidData), .cpuRdata(cpuRdata)
  );
endmodule

// File: tb/dramSlotSeq_tb.sv
module dramSlotSeq_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int ROW_W  = ADDR_W / 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vidHalfRate = 1'b0;
  logic [ADDR_W-1:0] vidAddr = '0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic cpuWrite = 1'b0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] ramDin;
  logic [ROW_W-1:0] ramAddr;
  logic ramRasN, ramCasN, ramWeN, cpuPhi2, vidStrobe;
  logic [DATA_W-1:0] ramWdata, vidData, cpuRdata;

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] gold [DEPTH];
  logic [ROW_W-1:0]  rowLatch = '0;

  int checks = 0;
  int errors = 0;
  int benchTick = 0;
  bit finished = 1'b0;

  always #5 clk = !clk;

  dramSlotSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .vidHalfRate(vidHalfRate), .vidAddr(vidAddr),
    .cpuAddr(cpuAddr), .cpuWrite(cpuWrite), .cpuWdata(cpuWdata), .ramDin(ramDin),
    .ramAddr(ramAddr), .ramRasN(ramRasN), .ramCasN(ramCasN), .ramWeN(ramWeN),
    .ramWdata(ramWdata), .cpuPhi2(cpuPhi2), .vidStrobe(vidStrobe),
    .vidData(vidData), .cpuRdata(cpuRdata)
  );

  // Behavioural DRAM: row taken while the row strobe is low and the column strobe is high
  always @(posedge clk) begin
    if (!ramRasN && ramCasN) rowLatch <= ramAddr;
    if (!ramCasN && !ramWeN) mem[{ramAddr, rowLatch}] <= ramWdata;
  end
  assign ramDin = mem[{ramAddr, rowLatch}];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]  = DATA_W'(i * 7 + 3);
      gold[i] = DATA_W'(i * 7 + 3);
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s tick=%0d actual=%0h expected=%0h", req, what, benchTick, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    benchTick++;
    #1;
  endtask

  task automatic gotoTick(int k);
    step();
    while (benchTick % 8 != k) step();
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "rasN in reset", 32'(ramRasN), 1);
    check("R1", "casN in reset", 32'(ramCasN), 1);
    check("R1", "weN in reset", 32'(ramWeN), 1);
    check("R1", "phi2 in reset", 32'(cpuPhi2), 0);
    check("R1", "vidStrobe in reset", 32'(vidStrobe), 0);
    check("R1", "vidData reset", 32'(vidData), 0);
    check("R1", "cpuRdata reset", 32'(cpuRdata), 0);
    rst = 1'b0;
    #1;
    benchTick = 0;
    check("R1", "rasN first tick", 32'(ramRasN), 0);
  endtask

  task automatic testStrobes();
    gotoTick(0);
    for (int i = 0; i < 16; i++) begin
      check("R2", "rasN", 32'(ramRasN), (i % 4 == 3) ? 1 : 0);
      check("R2", "casN", 32'(ramCasN), ((i % 4 == 1) || (i % 4 == 2)) ? 0 : 1);
      check("R9", "phi2", 32'(cpuPhi2), ((i % 8) >= 4) ? 1 : 0);
      step();
    end
  endtask

  task automatic testAddrMux();
    vidAddr = 8'hA5;
    cpuAddr = 8'h3C;
    gotoTick(0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] src;
      src = (i < 4) ? 8'hA5 : 8'h3C;
      check((i < 4) ? "R3" : "R4", "ramAddr", 32'(ramAddr),
            32'((i % 4 == 0) ? src[3:0] : src[7:4]));
      step();
    end
  endtask

  task automatic testVideo();
    vidHalfRate = 1'b0;
    for (int n = 0; n < 2; n++) begin
      logic [7:0] a;
      a = (n == 0) ? 8'h12 : 8'hE9;
      gotoTick(0);
      vidAddr = a;
      gotoTick(2);
      check("R6", "vidStrobe tick2", 32'(vidStrobe), 1);
      gotoTick(3);
      check("R6", "vidData", 32'(vidData), 32'(gold[a]));
      check("R6", "vidStrobe tick3", 32'(vidStrobe), 0);
    end
  endtask

  task automatic testHalfRate();
    vidHalfRate = 1'b1;
    step();
    while (!((benchTick % 8 == 0) && ((benchTick / 8) % 2 == 0))) step();
    vidAddr = 8'h21;
    gotoTick(3);
    check("R7", "even cycle capture", 32'(vidData), 32'(gold[8'h21]));
    gotoTick(0);
    vidAddr = 8'h40;
    check("R7", "odd cycle rasN runs", 32'(ramRasN), 0);
    gotoTick(2);
    check("R7", "odd cycle no strobe", 32'(vidStrobe), 0);
    check("R7", "odd cycle casN runs", 32'(ramCasN), 0);
    gotoTick(3);
    check("R7", "odd cycle holds", 32'(vidData), 32'(gold[8'h21]));
    gotoTick(3);
    check("R7", "next even capture", 32'(vidData), 32'(gold[8'h40]));
    vidHalfRate = 1'b0;
  endtask

  task automatic testCpu();
    cpuWrite = 1'b0;
    cpuAddr  = 8'h0F;
    gotoTick(7);
    check("R8", "cpu read", 32'(cpuRdata), 32'(gold[8'h0F]));
    gotoTick(3);
    cpuAddr  = 8'h5A;
    cpuWdata = 8'hC3;
    cpuWrite = 1'b1;
    #1;
    check("R5", "weN video slot", 32'(ramWeN), 1);
    check("R5", "wdata follows", 32'(ramWdata), 32'hC3);
    gotoTick(4);
    check("R5", "weN tick4", 32'(ramWeN), 0);
    gotoTick(6);
    check("R5", "weN tick6", 32'(ramWeN), 0);
    gotoTick(7);
    check("R5", "weN tick7", 32'(ramWeN), 1);
    check("R8", "write keeps rdata", 32'(cpuRdata), 32'(gold[8'h0F]));
    gold[8'h5A] = 8'hC3;
    gotoTick(0);
    cpuWrite = 1'b0;
    #1;
    check("R5", "weN after write", 32'(ramWeN), 1);
    gotoTick(7);
    check("R8", "read back", 32'(cpuRdata), 32'hC3);
  endtask

  task automatic testCollide();
    logic [7:0] oldVal;
    oldVal = gold[8'h77];
    gotoTick(0);
    vidAddr  = 8'h77;
    cpuAddr  = 8'h77;
    cpuWdata = 8'h19;
    cpuWrite = 1'b1;
    gotoTick(3);
    check("R6", "collide old video", 32'(vidData), 32'(oldVal));
    gold[8'h77] = 8'h19;
    gotoTick(0);
    cpuWrite = 1'b0;
    gotoTick(3);
    check("R6", "collide new video", 32'(vidData), 32'h19);
    gotoTick(7);
    check("R8", "collide cpu read", 32'(cpuRdata), 32'h19);
  endtask

  initial begin
    testReset();
    testStrobes();
    testAddrMux();
    testVideo();
    testHalfRate();
    testCpu();
    testCollide();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule